// File: doc/BRIEF.md
# Timestamped Display Flip Queue

This block keeps a short ordered list of pending surface flips for a single display plane. Each flip carries a 64-bit present ID, a surface address, a target time and a mode bit. A free-running time value and a VSync strobe come from outside. A flip is released only once the time value has reached its target. Flips in wait-for-VSync mode are released on a VSync edge. Flips in immediate (tearing) mode are released on the next clock. The released surface address is latched onto the scanout outputs.

When several pending flips have expired at a release point, only the most recently queued one is shown. The older ones are dropped. Every shown or dropped flip later leaves through a completion port as an (ID, timestamp) pair, one per clock, oldest first. A shown flip carries the release time. A dropped flip carries a reserved all-ones value.

Software can cancel the newest part of the queue by naming a first present ID. The block then reports the first ID it really removed. Flips already released to scanout are exempt from cancel: they complete normally.

Top module: `fq_flip_queue`

## Requirements
- R1: A push with no cancel in the same cycle, a non-full queue and a target time not below the newest queued entry's target is accepted: `push_ok` is 1 in that cycle, and `push_retry` and `push_err` are 0.
- R2: A push while the queue holds DEPTH entries (default 4) gets `push_retry`=1 and `push_ok`=0. The queue contents are left unchanged.
- R3: A push whose target time is below the target of the newest queued entry, and is not refused per R2 or R11, gets `push_err`=1 and is not stored.
- R4: A flip with `push_immed`=0 is released only in a cycle where `vsync`=1 and `now_time` >= its target. `scan_addr`/`scan_id` take its values on that clock edge, visible in the next cycle.
- R5: At a release, among the pending expired entries only the most recently queued one is shown. Every older pending expired entry is reported on the completion port with timestamp 64'hFFFF_FFFF_FFFF_FFFF.
- R6: If the newest pending expired entry has `push_immed`=1, it is released in that cycle even when `vsync`=0.
- R7: In a cycle with no release, `scan_addr` and `scan_id` hold their values and no new entry is marked for completion.
- R8: Released entries leave the completion port one per cycle in queue order, starting the cycle after their release. A shown entry carries the `now_time` value of its release cycle.
- R9: A cancel removes every non-released entry whose ID is >= `cancel_id`; IDs increase in push order. In the next cycle `cancel_ack`=1, `cancel_hit` tells whether anything was removed, and `cancel_first` gives the first removed ID (0 if none).
- R10: Entries released before or in the cancel cycle are never removed by a cancel and still appear on the completion port.
- R11: A push in the same cycle as a cancel gets `push_retry`=1 and is not stored.
- R12: After reset the queue is empty, `scan_addr`, `scan_id`, `cmp_valid` and `cancel_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_time | input | 64 | Free-running time value |
| vsync | input | 1 | VSync strobe, one cycle wide |
| push_valid | input | 1 | Push request |
| push_id | input | 64 | Present ID of pushed flip |
| push_addr | input | 32 | Surface address of pushed flip |
| push_tgt | input | 64 | Target time of pushed flip |
| push_immed | input | 1 | 1 = immediate (tearing) flip, 0 = wait for VSync |
| push_ok | output | 1 | Push accepted (same cycle) |
| push_retry | output | 1 | Push refused: queue full or cancel in progress |
| push_err | output | 1 | Push refused: target time goes backwards |
| cancel_valid | input | 1 | Cancel request |
| cancel_id | input | 64 | First present ID to cancel |
| cancel_ack | output | 1 | Cancel reply strobe |
| cancel_hit | output | 1 | Cancel removed at least one entry |
| cancel_first | output | 64 | First removed present ID |
| scan_addr | output | 32 | Surface address being scanned out |
| scan_id | output | 64 | Present ID being scanned out |
| cmp_valid | output | 1 | Completion record valid |
| cmp_id | output | 64 | Completed present ID |
| cmp_ts | output | 64 | Release time, or all ones if dropped |

## Verification
A wrong released-entry count shows up as a flip that is reported twice or never. It can also appear as a cancel that removes an entry already on screen. Either shows at the completion or cancel ports within a few cycles of the next release. A slot holding a stale target can release a flip early or late, which changes `scan_addr` at the wrong VSync edge. A broken ordering or count register makes push acceptance diverge at once, because `push_ok`, `push_retry` and `push_err` depend directly on the tail entry and the fill level.

// File: rtl/fq_pkg.sv
package fq_pkg;
    localparam int ID_W   = 64;
    localparam int ADDR_W = 32;
    localparam int TS_W   = 64;

    typedef logic [ID_W-1:0]   pid_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TS_W-1:0]   ts_t;

    typedef enum logic {
        MODE_VSYNC = 1'b0,
        MODE_IMMED = 1'b1
    } fmode_e;

    typedef struct packed {
        pid_t   id;
        addr_t  addr;
        ts_t    tgt;
        fmode_e mode;
        ts_t    done_ts;
    } fslot_t;

    localparam ts_t TS_DROPPED = {TS_W{1'b1}};

    function automatic logic is_due(input ts_t tgt, input ts_t now);
        return tgt <= now;
    endfunction
endpackage

// File: rtl/fq_expiry_pick.sv
module fq_expiry_pick
    import fq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  fslot_t         slots [DEPTH],
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  floor_n,
    input  ts_t            now,
    output logic           found,
    output logic [CW-1:0]  idx,
    output fslot_t         sel
);
    // Targets never decrease along the queue, so due entries form a prefix;
    // the last due one at or above the released floor is the newest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        sel   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt && CW'(i) >= floor_n && is_due(slots[i].tgt, now)) begin
                found = 1'b1;
                idx   = CW'(i);
                sel   = slots[i];
            end
        end
    end
endmodule

// File: rtl/fq_cancel_find.sv
module fq_cancel_find
    import fq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  fslot_t         slots [DEPTH],
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  floor_n,
    input  pid_t           first_id,
    output logic           hit,
    output logic [CW-1:0]  pos,
    output pid_t           hit_id
);
    always_comb begin
        hit    = 1'b0;
        pos    = '0;
        hit_id = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && CW'(i) < cnt && CW'(i) >= floor_n && slots[i].id >= first_id) begin
                hit    = 1'b1;
                pos    = CW'(i);
                hit_id = slots[i].id;
            end
        end
    end
endmodule

// File: rtl/fq_flip_queue.sv
module fq_flip_queue
    import fq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   now_time,
    input  logic              vsync,
    input  logic              push_valid,
    input  logic [ID_W-1:0]   push_id,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TS_W-1:0]   push_tgt,
    input  logic              push_immed,
    output logic              push_ok,
    output logic              push_retry,
    output logic              push_err,
    input  logic              cancel_valid,
    input  logic [ID_W-1:0]   cancel_id,
    output logic              cancel_ack,
    output logic              cancel_hit,
    output logic [ID_W-1:0]   cancel_first,
    output logic [ADDR_W-1:0] scan_addr,
    output logic [ID_W-1:0]   scan_id,
    output logic              cmp_valid,
    output logic [ID_W-1:0]   cmp_id,
    output logic [TS_W-1:0]   cmp_ts
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

    // Queue storage: index 0 is oldest. Entries [0, rel_q) are released and
    // wait only for their completion record; [rel_q, cnt_q) are pending.
    fslot_t        slot_q [DEPTH];
    fslot_t        slot_n [DEPTH];
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] rel_q, rel_n;

    logic          due_found;
    logic [CW-1:0] due_idx;
    fslot_t        due_sel;
    logic          fire;
    logic [CW-1:0] rel_after_fire;

    logic          c_hit;
    logic [CW-1:0] c_pos;
    pid_t          c_id;

    ts_t           tail_tgt;
    logic          full, backwards, pop;

    fq_expiry_pick #(.DEPTH(DEPTH), .CW(CW)) u_pick (
        .slots   (slot_q),
        .cnt     (cnt_q),
        .floor_n (rel_q),
        .now     (now_time),
        .found   (due_found),
        .idx     (due_idx),
        .sel     (due_sel)
    );

    assign fire           = due_found && (vsync || due_sel.mode == MODE_IMMED);
    assign rel_after_fire = fire ? due_idx + CW'(1) : rel_q;

    fq_cancel_find #(.DEPTH(DEPTH), .CW(CW)) u_cancel (
        .slots    (slot_q),
        .cnt      (cnt_q),
        .floor_n  (rel_after_fire),
        .first_id (cancel_id),
        .hit      (c_hit),
        .pos      (c_pos),
        .hit_id   (c_id)
    );

    always_comb begin
        tail_tgt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) + CW'(1) == cnt_q) tail_tgt = slot_q[i].tgt;
        end
    end

    assign full       = (cnt_q == FULL_N);
    assign backwards  = (cnt_q != '0) && (push_tgt < tail_tgt);
    assign push_retry = push_valid && (cancel_valid || full);
    assign push_err   = push_valid && !push_retry && backwards;
    assign push_ok    = push_valid && !push_retry && !backwards;
    assign pop        = (rel_q != '0);

    always_comb begin
        slot_n = slot_q;
        cnt_n  = cnt_q;
        rel_n  = rel_after_fire;
        if (fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) >= rel_q && CW'(i) <= due_idx)
                    slot_n[i].done_ts = (CW'(i) == due_idx) ? now_time : TS_DROPPED;
            end
        end
        if (cancel_valid && c_hit) cnt_n = c_pos;
        if (push_ok) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == cnt_q)
                    slot_n[i] = '{id: push_id, addr: push_addr, tgt: push_tgt,
                                  mode: fmode_e'(push_immed), done_ts: '0};
            end
            cnt_n = cnt_q + CW'(1);
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot_n[i+1];
            slot_n[DEPTH-1] = '0;
            cnt_n = cnt_n - CW'(1);
            rel_n = rel_n - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q       <= '{default: '0};
            cnt_q        <= '0;
            rel_q        <= '0;
            scan_addr    <= '0;
            scan_id      <= '0;
            cmp_valid    <= 1'b0;
            cmp_id       <= '0;
            cmp_ts       <= '0;
            cancel_ack   <= 1'b0;
            cancel_hit   <= 1'b0;
            cancel_first <= '0;
        end else begin
            slot_q       <= slot_n;
            cnt_q        <= cnt_n;
            rel_q        <= rel_n;
            if (fire) begin
                scan_addr <= due_sel.addr;
                scan_id   <= due_sel.id;
            end
            cmp_valid    <= pop;
            if (pop) begin
                cmp_id <= slot_q[0].id;
                cmp_ts <= slot_q[0].done_ts;
            end
            cancel_ack   <= cancel_valid;
            cancel_hit   <= cancel_valid && c_hit;
            cancel_first <= (cancel_valid && c_hit) ? c_id : '0;
        end
    end

    // ---------------- assertions ----------------
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_N);

    p_full_unchanged_r2: assert property (@(posedge clk) disable iff (rst)
        (push_valid && full && !pop && !cancel_valid) |=> cnt_q == FULL_N);

    generate
        for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
            p_tgt_nondecr_r3: assert property (@(posedge clk) disable iff (rst)
                (CW'(g + 1) < cnt_q) |-> slot_q[g].tgt <= slot_q[g+1].tgt);
        end
    endgenerate

    p_scan_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(scan_addr) && $stable(scan_id)));

    p_cmp_in_order_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && $past(cmp_valid) && !$past(rst)) |-> cmp_id > $past(cmp_id));

    p_released_bound_r10: assert property (@(posedge clk) disable iff (rst)
        rel_q <= cnt_q);

    p_cancel_reply_r9: assert property (@(posedge clk) disable iff (rst)
        cancel_valid |=> cancel_ack);
endmodule

// File: tb/tb_fq_flip_queue.sv
module tb_fq_flip_queue;
    localparam int  DEPTH  = 4;
    localparam time CLK_T  = 10;
    localparam logic [63:0] DROP = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] now_time;
    logic        vsync, push_valid, push_immed, cancel_valid;
    logic [63:0] push_id, push_tgt, cancel_id;
    logic [31:0] push_addr;
    logic        push_ok, push_retry, push_err;
    logic        cancel_ack, cancel_hit, cmp_valid;
    logic [63:0] cancel_first, scan_id, cmp_id, cmp_ts;
    logic [31:0] scan_addr;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_T/2) clk = ~clk;

    fq_flip_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .now_time(now_time), .vsync(vsync),
        .push_valid(push_valid), .push_id(push_id), .push_addr(push_addr),
        .push_tgt(push_tgt), .push_immed(push_immed),
        .push_ok(push_ok), .push_retry(push_retry), .push_err(push_err),
        .cancel_valid(cancel_valid), .cancel_id(cancel_id),
        .cancel_ack(cancel_ack), .cancel_hit(cancel_hit), .cancel_first(cancel_first),
        .scan_addr(scan_addr), .scan_id(scan_id),
        .cmp_valid(cmp_valid), .cmp_id(cmp_id), .cmp_ts(cmp_ts)
    );

    // reference queue built from the requirements
    logic [63:0] m_id [DEPTH];
    logic [31:0] m_addr [DEPTH];
    logic [63:0] m_tgt [DEPTH];
    bit          m_im [DEPTH];
    logic [63:0] m_done [DEPTH];
    int          m_cnt = 0;
    int          m_rel = 0;
    logic [31:0] e_saddr = '0;
    logic [63:0] e_sid = '0;
    logic [63:0] tnow = 64'd100;
    logic [63:0] next_id = 64'd1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit pv, input logic [63:0] pid, input logic [31:0] pa,
                        input logic [63:0] pt, input bit pim, input bit vs,
                        input bit cv, input logic [63:0] cid);
        bit full, bad, e_ok, e_retry, e_err, found, fire, e_hit, e_cv;
        int k, pos, newrel, oldrel;
        logic [63:0] e_first, e_cid, e_cts;
        string tag;
        push_valid = pv; push_id = pid; push_addr = pa; push_tgt = pt;
        push_immed = pim; vsync = vs; cancel_valid = cv; cancel_id = cid;
        now_time = tnow;
        #1;
        full = (m_cnt == DEPTH);
        bad = 1'b0;
        if (m_cnt > 0) bad = (pt < m_tgt[m_cnt-1]);
        e_retry = pv && (cv || full);
        e_err = pv && !e_retry && bad;
        e_ok = pv && !e_retry && !bad;
        tag = cv ? "R11" : (full ? "R2" : (bad ? "R3" : "R1"));
        if (pv)
            chk({push_ok, push_retry, push_err} == {e_ok, e_retry, e_err}, tag,
                "push ok/retry/err", {push_ok, push_retry, push_err}, {e_ok, e_retry, e_err});
        // release decision
        found = 0; k = 0;
        for (int i = m_rel; i < m_cnt; i++)
            if (m_tgt[i] <= tnow) begin found = 1; k = i; end
        fire = found && (vs || m_im[k]);
        oldrel = m_rel;
        newrel = m_rel;
        if (fire) begin
            for (int i = m_rel; i <= k; i++) m_done[i] = (i == k) ? tnow : DROP;
            e_saddr = m_addr[k]; e_sid = m_id[k];
            newrel = k + 1;
        end
        // cancel
        e_hit = 0; e_first = '0; pos = 0;
        if (cv)
            for (int i = newrel; i < m_cnt; i++)
                if (!e_hit && m_id[i] >= cid) begin e_hit = 1; e_first = m_id[i]; pos = i; end
        if (e_hit) m_cnt = pos;
        // push
        if (e_ok) begin
            m_id[m_cnt] = pid; m_addr[m_cnt] = pa; m_tgt[m_cnt] = pt;
            m_im[m_cnt] = pim; m_done[m_cnt] = '0;
            m_cnt++;
        end
        // completion
        e_cv = (oldrel > 0);
        e_cid = m_id[0]; e_cts = m_done[0];
        if (e_cv) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_id[i] = m_id[i+1]; m_addr[i] = m_addr[i+1]; m_tgt[i] = m_tgt[i+1];
                m_im[i] = m_im[i+1]; m_done[i] = m_done[i+1];
            end
            m_cnt--; newrel--;
        end
        m_rel = newrel;
        @(posedge clk);
        @(negedge clk);
        tag = fire ? (vs ? "R4" : "R6") : "R7";
        chk({scan_addr, scan_id} == {e_saddr, e_sid}, tag, "scan addr/id",
            {scan_addr, scan_id}, {e_saddr, e_sid});
        chk(cmp_valid == e_cv, "R8", "cmp_valid", cmp_valid, e_cv);
        if (e_cv && cmp_valid) begin
            tag = (e_cts == DROP) ? "R5" : "R8";
            chk({cmp_id, cmp_ts} == {e_cid, e_cts}, tag, "completion id/ts",
                {cmp_id, cmp_ts}, {e_cid, e_cts});
        end
        chk({cancel_ack, cancel_hit, cancel_first} == {cv, e_hit, e_first}, "R9",
            "cancel ack/hit/first", {cancel_ack, cancel_hit, cancel_first}, {cv, e_hit, e_first});
        tnow = tnow + 1;
    endtask

    task automatic idle(input int n, input bit vs);
        for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, vs, 0, '0);
    endtask

    initial begin
        #(CLK_T * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] tail, pt;
        bit pv, cv, pim, vs;
        void'($urandom(32'd4242));
        rst = 1'b1; vsync = 0; push_valid = 0; cancel_valid = 0; push_immed = 0;
        push_id = '0; push_addr = '0; push_tgt = '0; cancel_id = '0; now_time = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk({scan_addr, scan_id} == '0, "R12", "scan after reset", {scan_addr, scan_id}, '0);
        chk({cmp_valid, cancel_ack} == 2'b00, "R12", "strobes after reset", {cmp_valid, cancel_ack}, '0);

        // fill with future flips, then overflow (R2)
        for (int i = 0; i < DEPTH; i++) begin
            step(1, next_id, 32'h1000 + i, tnow + 40 + i, 0, 0, 0, '0);
            next_id++;
        end
        step(1, next_id, 32'h1F00, tnow + 60, 0, 0, 0, '0); next_id++;
        // vsync with nothing due (R7)
        idle(1, 1);
        // cancel the tail from ID 3 (R9)
        step(0, '0, '0, '0, 0, 0, 1, 64'd3);
        // backwards target (R3)
        step(1, next_id, 32'h2000, 64'd10, 0, 0, 0, '0); next_id++;
        // several due at one vsync (R5)
        idle(50, 0);
        idle(1, 1);
        idle(4, 0);
        // released flips cannot be cancelled (R10)
        step(1, 64'd20, 32'h3000, tnow, 0, 0, 0, '0);
        step(1, 64'd21, 32'h3100, tnow, 0, 0, 0, '0);
        idle(1, 1);
        step(0, '0, '0, '0, 0, 0, 1, 64'd21);
        chk(cancel_hit == 1'b0, "R10", "cancel of released flip", cancel_hit, 1'b0);
        idle(3, 0);
        next_id = 64'd30;
        // immediate flip released without vsync (R6)
        step(1, next_id, 32'h4000, tnow + 2, 1, 0, 0, '0); next_id++;
        idle(5, 0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            tail = (m_cnt > 0) ? m_tgt[m_cnt-1] : tnow - 3;
            pv  = ($urandom % 2) == 0;
            cv  = ($urandom % 12) == 0;
            pim = ($urandom % 4) == 0;
            vs  = (tnow % 6) == 0;
            if (($urandom % 10) == 0 && m_cnt > 0) pt = tail - 1;
            else pt = tail + ($urandom % 9);
            step(pv, next_id, $urandom, pt, pim, vs, cv, next_id - ($urandom % 5));
            next_id++;
        end
        idle(12, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule